// File: doc/BRIEF.md
# Debug Serial Port Register Front-End

This block is the software-visible register layer of a simple debug serial port. A processor reaches it over a 32-bit register bus with byte addresses and word-sized registers. It holds a control register, an interrupt mask that is changed through separate set and clear ports, a live status word, a receive holding register, a transmit holding register, and two plain configuration words. A single level interrupt line goes to the system interrupt controller.

Characters written for transmission leave the block on a byte-wide output with a one-cycle valid strobe. A fixed-latency model stands in for the serial line: it reports the character as finished a set number of cycles after the write. Incoming bytes arrive on a byte-wide input with a valid strobe. The block takes a byte only while its receive holding register is empty, and it shows that state on a ready output.

Top module: `dbg_uart_regs`

## Requirements
- R1: After reset, the status word (offset 0x14) reads 0x202, meaning bit 1 (transmit-ready) and bit 9 (transmitter-empty) are set. Every other register reads zero, irq is low, rx_ready is high and tx_valid is low.
- R2: A control write (offset 0x00) with bit 6 set sets status bits 1 and 9. A control write with bit 7 set clears both bits. When both bits are set in one write, bits 1 and 9 end up cleared. A control write with neither bit set leaves the flags unchanged.
- R3: A write to offset 0x08 ORs the data into the interrupt mask. A write to offset 0x0C clears the mask bits that are set in the data. The mask reads back at offset 0x10. Offsets 0x08 and 0x0C read zero.
- R4: A write to the transmit holding register (offset 0x1C) clears status bits 1 and 9. In the next cycle it drives tx_valid high for exactly one cycle, with tx_data equal to the low byte of the written data.
- R5: Status bits 1 and 9 are set again on the TX_LAT-th clock edge after the holding-register write. A new write before that point restarts the count.
- R6: While status bit 0 (receive-ready) is clear, a byte presented with rx_valid is latched into the receive holding register (offset 0x18) and sets bit 0. rx_ready then goes low.
- R7: A byte presented while bit 0 is set is dropped, and the receive holding register keeps its old byte.
- R8: A read of offset 0x18 clears status bit 0, and rx_ready is high again from the next cycle.
- R9: irq is high exactly when the mask ANDed with the status word is nonzero. It follows a change of mask or status from the cycle after that change.
- R10: Offsets 0x00, 0x04 and 0x20 store the full written word and read it back. Offset 0x1C reads back the last transmitted byte.
- R11: Reads of unimplemented or misaligned addresses (for example 0x24 and 0x3C) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational during a read, zero otherwise |
| tx_data | output | CHAR_W | Outgoing character |
| tx_valid | output | 1 | One-cycle strobe for tx_data |
| rx_data | input | CHAR_W | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | High while a byte can be accepted |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong transmit flag shows at the status read and on irq as soon as the transmit-ready bit is unmasked. A miscounted completion timer moves the status change away from the exact TX_LAT edge, and the bench probes the cycles on both sides of that edge. A receive latch that takes a byte while it is full changes the value read back from the holding register, which the bench reads straight after a second byte is offered. A mask update with the wrong polarity shows up in the next mask read-back and on irq one cycle later.

// File: rtl/dbgu_pkg.sv
package dbgu_pkg;
  // word indices of the implemented registers
  localparam int unsigned W_CTRL  = 0;
  localparam int unsigned W_MODE  = 1;
  localparam int unsigned W_IEN   = 2;
  localparam int unsigned W_IDIS  = 3;
  localparam int unsigned W_MASK  = 4;
  localparam int unsigned W_STAT  = 5;
  localparam int unsigned W_RHOLD = 6;
  localparam int unsigned W_THOLD = 7;
  localparam int unsigned W_BAUD  = 8;

  // status and control bit positions
  localparam int unsigned ST_RXRDY   = 0;
  localparam int unsigned ST_TXRDY   = 1;
  localparam int unsigned ST_TXEMPTY = 9;
  localparam int unsigned CT_TXON    = 6;
  localparam int unsigned CT_TXOFF   = 7;

  typedef enum logic [3:0] {
    RS_NONE, RS_CTRL, RS_MODE, RS_IEN, RS_IDIS, RS_MASK,
    RS_STAT, RS_RHOLD, RS_THOLD, RS_BAUD
  } reg_sel_e;
endpackage

// File: rtl/dbgu_tx_timer.sv
module dbgu_tx_timer #(
  parameter int unsigned LAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done   = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/dbgu_rx_hold.sv
module dbgu_rx_hold #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              consume,
  output logic              full,
  output logic [CHAR_W-1:0] data
);
  logic              full_q, full_d, take;
  logic [CHAR_W-1:0] data_q;

  assign take = in_valid & ~full_q;

  always_comb begin
    full_d = full_q;
    if (consume) full_d = 1'b0;
    if (take)    full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (take) data_q <= in_data;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/dbg_uart_regs.sv
module dbg_uart_regs
  import dbgu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned TX_LAT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned PAD_W  = DATA_W - CHAR_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  logic [WIDX_W-1:0] widx;
  reg_sel_e          rsel;
  logic              wr_en, rd_en;
  assign widx  = bus_addr[ADDR_W-1:2];
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_comb begin
    rsel = RS_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      case (widx)
        WIDX_W'(W_CTRL):  rsel = RS_CTRL;
        WIDX_W'(W_MODE):  rsel = RS_MODE;
        WIDX_W'(W_IEN):   rsel = RS_IEN;
        WIDX_W'(W_IDIS):  rsel = RS_IDIS;
        WIDX_W'(W_MASK):  rsel = RS_MASK;
        WIDX_W'(W_STAT):  rsel = RS_STAT;
        WIDX_W'(W_RHOLD): rsel = RS_RHOLD;
        WIDX_W'(W_THOLD): rsel = RS_THOLD;
        WIDX_W'(W_BAUD):  rsel = RS_BAUD;
        default:          rsel = RS_NONE;
      endcase
    end
  end

  logic ctrl_we, mode_we, baud_we, ien_we, idis_we, thr_we, rhr_re;
  assign ctrl_we = wr_en & (rsel == RS_CTRL);
  assign mode_we = wr_en & (rsel == RS_MODE);
  assign baud_we = wr_en & (rsel == RS_BAUD);
  assign ien_we  = wr_en & (rsel == RS_IEN);
  assign idis_we = wr_en & (rsel == RS_IDIS);
  assign thr_we  = wr_en & (rsel == RS_THOLD);
  assign rhr_re  = rd_en & (rsel == RS_RHOLD);

  // state
  logic [DATA_W-1:0] ctrl_q, mode_q, baud_q, mask_q, mask_d;
  logic [CHAR_W-1:0] thr_q;
  logic              tx_idle_q, tx_idle_d, txv_q;
  logic              tx_done, rx_full;
  logic [CHAR_W-1:0] rx_byte;
  logic [DATA_W-1:0] stat;

  dbgu_tx_timer #(.LAT(TX_LAT)) u_txt (
    .clk(clk), .rst_n(rst_int_n), .start(thr_we), .done(tx_done)
  );

  dbgu_rx_hold #(.CHAR_W(CHAR_W)) u_rxh (
    .clk(clk), .rst_n(rst_int_n), .in_valid(rx_valid), .in_data(rx_data),
    .consume(rhr_re), .full(rx_full), .data(rx_byte)
  );

  // next state: later statements take precedence
  always_comb begin
    tx_idle_d = tx_idle_q;
    if (tx_done)                     tx_idle_d = 1'b1;
    if (ctrl_we && bus_wdata[CT_TXON])  tx_idle_d = 1'b1;
    if (ctrl_we && bus_wdata[CT_TXOFF]) tx_idle_d = 1'b0;
    if (thr_we)                      tx_idle_d = 1'b0;

    mask_d = mask_q;
    if (ien_we)  mask_d = mask_q | bus_wdata;
    if (idis_we) mask_d = mask_q & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q    <= '0;
      mode_q    <= '0;
      baud_q    <= '0;
      mask_q    <= '0;
      thr_q     <= '0;
      tx_idle_q <= 1'b1;
      txv_q     <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= bus_wdata;
      if (mode_we) mode_q <= bus_wdata;
      if (baud_we) baud_q <= bus_wdata;
      if (thr_we)  thr_q  <= bus_wdata[CHAR_W-1:0];
      mask_q    <= mask_d;
      tx_idle_q <= tx_idle_d;
      txv_q     <= thr_we;
    end
  end

  always_comb begin
    stat             = '0;
    stat[ST_RXRDY]   = rx_full;
    stat[ST_TXRDY]   = tx_idle_q;
    stat[ST_TXEMPTY] = tx_idle_q;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (rsel)
        RS_CTRL:  bus_rdata = ctrl_q;
        RS_MODE:  bus_rdata = mode_q;
        RS_MASK:  bus_rdata = mask_q;
        RS_STAT:  bus_rdata = stat;
        RS_RHOLD: bus_rdata = {{PAD_W{1'b0}}, rx_byte};
        RS_THOLD: bus_rdata = {{PAD_W{1'b0}}, thr_q};
        RS_BAUD:  bus_rdata = baud_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign tx_data  = thr_q;
  assign tx_valid = txv_q;
  assign rx_ready = ~rx_full;
  assign irq      = |(mask_q & stat);
endmodule

// File: rtl/dbgu_chk.sv
module dbgu_chk
  import dbgu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CHAR_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [DATA_W-1:0] mask_q,
  input logic [CHAR_W-1:0] rx_byte
);
  logic thr_wr, idis_all;
  assign thr_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(W_THOLD * 4));
  assign idis_all = bus_sel && bus_wr && (bus_addr == ADDR_W'(W_IDIS * 4)) && (&bus_wdata);

  // R4
  tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> tx_valid && (tx_data == $past(bus_wdata[CHAR_W-1:0])));

  // R4
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(thr_wr));

  // R6
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  // R7
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |=> $stable(rx_byte));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idis_all |=> !irq);
endmodule

bind dbg_uart_regs dbgu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_data(tx_data),
  .tx_valid(tx_valid), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .irq(irq), .mask_q(mask_q), .rx_byte(rx_byte)
);

// File: tb/sim_dbg_uart_regs.sv
module sim_dbg_uart_regs;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 8;
  localparam int unsigned NV = 18;
  localparam int unsigned VW = 1 + AW + DW + DW + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [CW-1:0] tx_data, rx_data;
  logic          tx_valid, rx_valid, rx_ready, irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] rd;

  always #10 clk = ~clk;

  dbg_uart_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
  );

  // {write, addr, wdata, expected read, requirement number}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 8'h04, 32'h0000_00A7, 32'h0, 4'd10},   // R10
    {1'b0, 8'h04, 32'h0, 32'h0000_00A7, 4'd10},   // R10
    {1'b1, 8'h20, 32'h0001_1234, 32'h0, 4'd10},   // R10
    {1'b0, 8'h20, 32'h0, 32'h0001_1234, 4'd10},   // R10
    {1'b1, 8'h00, 32'h0000_0005, 32'h0, 4'd10},   // R10
    {1'b0, 8'h00, 32'h0, 32'h0000_0005, 4'd10},   // R10
    {1'b1, 8'h08, 32'h0000_0300, 32'h0, 4'd3},    // R3
    {1'b1, 8'h08, 32'h0000_0001, 32'h0, 4'd3},    // R3
    {1'b0, 8'h10, 32'h0, 32'h0000_0301, 4'd3},    // R3
    {1'b1, 8'h0C, 32'h0000_0100, 32'h0, 4'd3},    // R3
    {1'b0, 8'h10, 32'h0, 32'h0000_0201, 4'd3},    // R3
    {1'b0, 8'h08, 32'h0, 32'h0, 4'd3},            // R3
    {1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0, 4'd11},   // R11
    {1'b0, 8'h24, 32'h0, 32'h0, 4'd11},           // R11
    {1'b0, 8'h3C, 32'h0, 32'h0, 4'd11},           // R11
    {1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0, 4'd3},    // R3
    {1'b0, 8'h10, 32'h0, 32'h0, 4'd3},            // R3
    {1'b0, 8'h14, 32'h0, 32'h0000_0202, 4'd2}     // R2: control write without bits 6/7
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1'b1, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_data = '0; rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(8'h14, rd); check("R1 status", rd, 32'h202);
    bus_read(8'h10, rd); check("R1 mask", rd, 32'h0);
    bus_read(8'h00, rd); check("R1 control", rd, 32'h0);
    bus_read(8'h18, rd); check("R1 rx hold", rd, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      if (v[VW-1]) bus_write(v[VW-2 -: AW], v[DW+DW+3 -: DW]);
      else begin
        bus_read(v[VW-2 -: AW], rd);
        check($sformatf("R%0d vector %0d", v[3:0], i), rd, v[DW+3 -: DW]);
      end
    end

    // R2 / R9 control enable and disable of the transmit flags
    bus_write(8'h08, 32'h2);
    check("R9 irq on txrdy", {31'b0, irq}, 32'h1);
    bus_write(8'h00, 32'h80);
    bus_read(8'h14, rd); check("R2 disable clears", rd, 32'h0);
    check("R9 irq drops", {31'b0, irq}, 32'h0);
    bus_write(8'h00, 32'h40);
    bus_read(8'h14, rd); check("R2 enable sets", rd, 32'h202);
    check("R9 irq rises", {31'b0, irq}, 32'h1);
    bus_write(8'h00, 32'hC0);
    bus_read(8'h14, rd); check("R2 both bits clear", rd, 32'h0);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_write(8'h00, 32'h40);

    // R4 / R5 transmit
    bus_write(8'h1C, 32'h0000_01C5);
    check("R4 tx_valid", {31'b0, tx_valid}, 32'h1);
    check("R4 tx_data", {24'b0, tx_data}, 32'hC5);
    bus_read(8'h14, rd); check("R4 flags cleared", rd, 32'h0);
    check("R4 single pulse", {31'b0, tx_valid}, 32'h0);
    repeat (8) @(negedge clk);
    bus_read(8'h14, rd); check("R5 before latency", rd, 32'h0);
    bus_read(8'h14, rd); check("R5 at latency", rd, 32'h202);
    bus_read(8'h1C, rd); check("R10 tx hold readback", rd, 32'hC5);

    // R5 restart on a second write
    bus_write(8'h1C, 32'h11);
    repeat (4) @(negedge clk);
    bus_write(8'h1C, 32'h22);
    repeat (4) @(negedge clk);
    bus_read(8'h14, rd); check("R5 restart a", rd, 32'h0);
    bus_read(8'h14, rd); check("R5 restart b", rd, 32'h0);
    repeat (2) @(negedge clk);
    bus_read(8'h14, rd); check("R5 restart c", rd, 32'h0);
    bus_read(8'h14, rd); check("R5 restart d", rd, 32'h0);
    bus_read(8'h14, rd); check("R5 restart done", rd, 32'h202);

    // R6 / R7 / R8 receive
    bus_write(8'h08, 32'h1);
    check("R9 no irq while empty", {31'b0, irq}, 32'h0);
    rx_valid = 1'b1; rx_data = 8'hA5;
    @(negedge clk);
    check("R6 rx_ready low", {31'b0, rx_ready}, 32'h0);
    check("R9 irq on rx", {31'b0, irq}, 32'h1);
    rx_data = 8'h3C;
    @(negedge clk);
    rx_valid = 1'b0;
    bus_read(8'h14, rd); check("R6 status rxrdy", rd, 32'h203);
    bus_read(8'h18, rd); check("R7 byte kept", rd, 32'hA5);
    check("R8 rx_ready back", {31'b0, rx_ready}, 32'h1);
    check("R9 irq clears", {31'b0, irq}, 32'h0);
    bus_read(8'h14, rd); check("R8 status cleared", rd, 32'h202);
    rx_valid = 1'b1; rx_data = 8'h5A;
    @(negedge clk);
    rx_valid = 1'b0;
    bus_read(8'h18, rd); check("R6 second byte", rd, 32'h5A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule